// File: doc/BRIEF.md
# Programmable Pixel Clock Divider with Period Skipping

This block derives the LCD shift clock from a base clock. The division ratio is a 5-bit code plus two, so the output period can be anywhere from 2 to 33 base-clock cycles. Each output period starts with its high phase. For odd ratios the high phase is the shorter half. A one-cycle strobe marks each rising edge of the shift clock, so logic in the base-clock domain can advance the pixel data path without watching the clock itself.

A skip option removes the high phase from every fourth output period. With a ratio of two, this produces three high pulses in every eight base cycles (a 3/8-rate clock). That rate suits a panel that shares fetched data with a concurrent video output. The base clock is chosen between the system bus clock (select 0) and the video PLL clock (select 1). Here that choice is modelled as a select output, taken up at a period boundary, and a qualifying enable that stays low for any period in which the source has just changed. The base clock itself is the single clock input of the block.

Top module: `pix_clk_div`

## Requirements
- R1: The output period is `pcd_i + 2` base-clock cycles, for every code from 0 (period 2) to 31 (period 33).
- R2: Each period opens with `pclk_o` high for floor(period/2) cycles, and the rest of the period is low.
- R3: `pstrobe_o` is high for exactly one cycle, the cycle in which `pclk_o` goes from low to high, and at no other time.
- R4: While `skip_i` is 1, every fourth period counted from the period boundary at which skip was first seen is blanked: `pclk_o` and `pstrobe_o` stay low for that whole period. With `pcd_i = 0` this gives 24 high cycles in 64.
- R5: Any cycle with `skip_i` low clears the skip phase count. The next boundary with skip high then starts a new count, so the next blanked period is the fourth one after that boundary.
- R6: `pcd_i` is sampled only at a period boundary. A change in mid-period leaves the running period at its old length, and the new length applies from the next period.
- R7: While `rst_ni` is low, `pclk_o`, `pstrobe_o`, `src_sel_o` and `src_valid_o` are 0. The first clock edge after release is a period boundary.
- R8: At each period boundary `src_sel_o` takes the value of `src_sel_i` (0 = bus clock, 1 = video PLL clock). `src_valid_o` is 1 for the new period only if that value equals the previous period's select. The select before the first period counts as 0, so the first period is invalid unless the select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to clk_i |
| pcd_i | input | 5 | Divisor code; period is code + 2 cycles |
| skip_i | input | 1 | Blank every fourth output period |
| src_sel_i | input | 1 | Requested base clock source: 0 bus clock, 1 video PLL clock |
| pclk_o | output | 1 | Divided shift clock level |
| pstrobe_o | output | 1 | One-cycle pulse on each rising edge of pclk_o |
| src_sel_o | output | 1 | Source select applied for the current period |
| src_valid_o | output | 1 | Source unchanged since the previous period |

## Verification
The bench sweeps every divisor code with skip off and with skip on. It compares each cycle against an arithmetic model of period position. A design with an off-by-one ratio, or with the long half of an odd period placed high, would drift from the model within the first period. The skip sweep targets the placement of the blanked period: if the phase is counted from the wrong origin, the first blank lands on period three or five instead of four, and the 3/8 count comes out as something other than 24 of 64. Mid-period changes of the divisor and short drops of skip show whether the design takes the code up early, which would produce a runt period, and whether it keeps the skip phase across a cleared cycle.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  // The programmed code is offset by this amount to form the division ratio.
  localparam int RATIO_OFFSET = 2;

  typedef enum logic {
    SRC_BUS   = 1'b0,
    SRC_VIDEO = 1'b1
  } pcd_src_e;
endpackage

// File: rtl/pcd_period_ctr.sv
// Down-counter over one output period; reloads the ratio only at a boundary.
module pcd_period_ctr
  import pcd_pkg::*;
#(
  parameter int PCD_W = 5,
  parameter int CNT_W = PCD_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PCD_W-1:0] pcd_i,
  output logic             bnd_o,
  output logic [CNT_W-1:0] ratio_o,
  output logic             hi_nxt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] ratio_q, ratio_d;
  logic [CNT_W-1:0] lo_d;

  always_comb begin
    bnd_o   = (cnt_q == '0);
    ratio_d = ratio_q;
    cnt_d   = cnt_q - CNT_W'(1);
    if (bnd_o) begin
      ratio_d = CNT_W'(pcd_i) + CNT_W'(RATIO_OFFSET);
      cnt_d   = ratio_d - CNT_W'(1);
    end
    // low part is the ceiling half; high while remaining count is above it
    lo_d     = ratio_d - (ratio_d >> 1);
    hi_nxt_o = (cnt_d >= lo_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= CNT_W'(RATIO_OFFSET);
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end

  assign ratio_o = ratio_q;

endmodule

// File: rtl/pcd_skip_seq.sv
// Period phase counter for skip mode; decides whether the next period is blanked.
module pcd_skip_seq #(
  parameter int SKIP_PERIOD = 4,
  parameter int PH_W        = (SKIP_PERIOD > 1) ? $clog2(SKIP_PERIOD) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            skip_i,
  input  logic            bnd_i,
  output logic            blank_nxt_o,
  output logic [PH_W-1:0] phase_o
);

  generate
    if (SKIP_PERIOD > 1) begin : g_skip
      localparam logic [PH_W-1:0] LAST = PH_W'(SKIP_PERIOD - 1);
      logic [PH_W-1:0] phase_q, phase_d;
      logic            blank_q, blank_d;

      always_comb begin
        blank_d = blank_q;
        phase_d = phase_q;
        if (bnd_i) begin
          blank_d = skip_i && (phase_q == LAST);
          phase_d = (phase_q == LAST) ? '0 : phase_q + PH_W'(1);
        end
        if (!skip_i) phase_d = '0;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          phase_q <= '0;
          blank_q <= 1'b0;
        end else begin
          phase_q <= phase_d;
          blank_q <= blank_d;
        end
      end

      assign blank_nxt_o = blank_d;
      assign phase_o     = phase_q;
    end else begin : g_noskip
      assign blank_nxt_o = 1'b0;
      assign phase_o     = '0;
    end
  endgenerate

endmodule

// File: rtl/pcd_src_qual.sv
// Holds the base-clock source choice per period and flags periods after a change.
module pcd_src_qual
  import pcd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bnd_i,
  input  logic src_sel_i,
  output logic src_sel_o,
  output logic src_valid_o
);

  pcd_src_e sel_q, sel_d;
  logic     vld_q, vld_d;

  always_comb begin
    sel_d = sel_q;
    vld_d = vld_q;
    if (bnd_i) begin
      sel_d = pcd_src_e'(src_sel_i);
      vld_d = (pcd_src_e'(src_sel_i) == sel_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SRC_BUS;
      vld_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      vld_q <= vld_d;
    end
  end

  assign src_sel_o   = logic'(sel_q);
  assign src_valid_o = vld_q;

endmodule

// File: rtl/pix_clk_div.sv
module pix_clk_div
  import pcd_pkg::*;
#(
  parameter int PCD_W       = 5,
  parameter int SKIP_PERIOD = 4,
  localparam int CNT_W      = PCD_W + 1,
  localparam int PH_W       = (SKIP_PERIOD > 1) ? $clog2(SKIP_PERIOD) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PCD_W-1:0] pcd_i,
  input  logic             skip_i,
  input  logic             src_sel_i,
  output logic             pclk_o,
  output logic             pstrobe_o,
  output logic             src_sel_o,
  output logic             src_valid_o
);

  logic             bnd;
  logic [CNT_W-1:0] ratio;
  logic             hi_nxt;
  logic             blank_d;
  logic [PH_W-1:0]  phase;
  logic             pclk_d, pclk_q;
  logic             stb_d, stb_q;

  pcd_period_ctr #(.PCD_W(PCD_W), .CNT_W(CNT_W)) u_per (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pcd_i    (pcd_i),
    .bnd_o    (bnd),
    .ratio_o  (ratio),
    .hi_nxt_o (hi_nxt)
  );

  pcd_skip_seq #(.SKIP_PERIOD(SKIP_PERIOD), .PH_W(PH_W)) u_skip (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .skip_i      (skip_i),
    .bnd_i       (bnd),
    .blank_nxt_o (blank_d),
    .phase_o     (phase)
  );

  pcd_src_qual u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bnd_i       (bnd),
    .src_sel_i   (src_sel_i),
    .src_sel_o   (src_sel_o),
    .src_valid_o (src_valid_o)
  );

  always_comb begin
    pclk_d = hi_nxt && !blank_d;
    stb_d  = pclk_d && !pclk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      pclk_q <= pclk_d;
      stb_q  <= stb_d;
    end
  end

  assign pclk_o    = pclk_q;
  assign pstrobe_o = stb_q;

endmodule

// File: rtl/pix_clk_div_chk.sv
module pix_clk_div_chk #(
  parameter int PCD_W       = 5,
  parameter int CNT_W       = PCD_W + 1,
  parameter int SKIP_PERIOD = 4,
  parameter int PH_W        = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PCD_W-1:0] pcd_i,
  input logic             skip_i,
  input logic             src_sel_i,
  input logic             pclk_o,
  input logic             pstrobe_o,
  input logic             src_sel_o,
  input logic             src_valid_o,
  input logic             bnd,
  input logic [CNT_W-1:0] ratio,
  input logic [PH_W-1:0]  phase
);

  localparam logic [PH_W-1:0] LAST = PH_W'(SKIP_PERIOD - 1);

  // R6: ratio reloads from the code only at a boundary
  p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd |=> ratio == CNT_W'($past(pcd_i)) + CNT_W'(2));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd |=> $stable(ratio));

  // R3: strobe marks rising edges only
  p_rise_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pclk_o) |-> pstrobe_o);
  p_strobe_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstrobe_o |-> pclk_o);

  // R4: boundary with skip and last phase starts a blanked period
  p_blank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd && skip_i && phase == LAST) |=> (!pclk_o && !pstrobe_o));

  // R5: skip low clears the phase
  p_phase_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !skip_i |=> phase == '0);

  // R7: outputs quiet under reset
  p_reset_quiet_r7: assert property (@(posedge clk_i)
    !rst_ni |-> (!pclk_o && !pstrobe_o && !src_sel_o && !src_valid_o));

  // R8: select taken up at boundary
  p_src_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd |=> src_sel_o == $past(src_sel_i));
  p_src_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd |=> src_valid_o == ($past(src_sel_i) == $past(src_sel_o)));

endmodule

bind pix_clk_div pix_clk_div_chk #(
  .PCD_W(PCD_W), .CNT_W(CNT_W), .SKIP_PERIOD(SKIP_PERIOD), .PH_W(PH_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pcd_i(pcd_i), .skip_i(skip_i),
  .src_sel_i(src_sel_i), .pclk_o(pclk_o), .pstrobe_o(pstrobe_o),
  .src_sel_o(src_sel_o), .src_valid_o(src_valid_o),
  .bnd(bnd), .ratio(ratio), .phase(phase)
);

// File: tb/pix_clk_div_tb.sv
`timescale 1ns/1ps
module pix_clk_div_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] pcd;
  logic       skip;
  logic       sel;
  logic       pclk, stb, sel_o, val_o;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_tag = "R7";

  always #2 clk = ~clk;

  pix_clk_div u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pcd_i(pcd), .skip_i(skip),
    .src_sel_i(sel), .pclk_o(pclk), .pstrobe_o(stb),
    .src_sel_o(sel_o), .src_valid_o(val_o)
  );

  // Arithmetic model: position within the period, period length, skip count.
  int m_n, m_pos, m_sk;
  bit m_first, m_blank, m_sel, m_val;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_first = 1; m_n = 2; m_pos = 0; m_sk = 0;
      m_blank = 0; m_sel = 0; m_val = 0;
    end else if (m_first || m_pos == m_n - 1) begin
      m_first = 0;
      m_n     = int'(pcd) + 2;
      m_pos   = 0;
      m_blank = skip && (m_sk == 3);
      m_sk    = skip ? (m_sk + 1) % 4 : 0;
      m_val   = (sel == m_sel);
      m_sel   = sel;
    end else begin
      m_pos = m_pos + 1;
      if (!skip) m_sk = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance to the next falling edge and compare all outputs with the model.
  task automatic cyc();
    bit act_run, e_pclk, e_stb;
    @(negedge clk);
    act_run = rst_n && !m_first;
    e_pclk  = act_run && (m_pos < m_n / 2) && !m_blank;
    e_stb   = e_pclk && (m_pos == 0);
    if (!rst_n) begin
      chk("R7 pclk", int'(pclk), 0);
      chk("R7 strobe", int'(stb), 0);
      chk("R7 sel", int'(sel_o), 0);
      chk("R7 valid", int'(val_o), 0);
    end else begin
      chk({cur_tag, " pclk"}, int'(pclk), int'(e_pclk));
      chk("R3 strobe", int'(stb), int'(e_stb));
      chk("R8 sel", int'(sel_o), int'(m_sel));
      chk("R8 valid", int'(val_o), int'(m_val));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc();
    cyc();
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b1; pcd = '0; skip = 1'b0; sel = 1'b0;
    #1 rst_n = 1'b0;
    cyc(); cyc(); cyc();   // R7 reset state
    rst_n = 1'b1;

    // R1 R2 R4: every code, skip off and on, alternating source
    for (int p = 0; p < 32; p++) begin
      for (int s = 0; s < 2; s++) begin
        pcd = 5'(p); skip = s[0]; sel = p[0];
        cur_tag = (s != 0) ? "R4" : "R1 R2";
        do_reset();
        repeat (9 * (p + 2)) cyc();
      end
    end

    // R4: 3/8 rate with code 0
    begin
      int highs = 0;
      pcd = '0; skip = 1'b1; sel = 1'b0; cur_tag = "R4";
      do_reset();
      repeat (64) begin
        cyc();
        if (pclk) highs++;
      end
      chk("R4 high count in 64", highs, 24);
    end

    // R6: code changes in mid-period
    pcd = 5'd3; skip = 1'b0; cur_tag = "R6";
    do_reset();
    cyc(); cyc();
    pcd = 5'd1;  repeat (20) cyc();
    pcd = 5'd30; repeat (3) cyc();
    pcd = 5'd0;  repeat (80) cyc();

    // R5: skip dropped briefly and re-armed
    pcd = 5'd1; skip = 1'b1; cur_tag = "R5";
    do_reset();
    repeat (20) cyc();
    skip = 1'b0; cyc();
    skip = 1'b1; repeat (31) cyc();
    skip = 1'b0; repeat (6) cyc();
    skip = 1'b1; repeat (40) cyc();

    // R8: source changes
    pcd = 5'd2; skip = 1'b0; sel = 1'b0; cur_tag = "R8";
    do_reset();
    repeat (10) cyc();
    sel = 1'b1; repeat (10) cyc();
    sel = 1'b0; cyc();
    sel = 1'b1; repeat (12) cyc();

    finish_run();
  end

endmodule